// File: doc/BRIEF.md
# Multi-Length Delta History Prefetcher

This block watches the stream of cache-line misses and predicts the next line that will miss in the same physical page. Each miss arrives as a physical line address. The upper bits select the page and the low six bits give the line within a 4 KB page of 64-byte lines. A small tracker remembers, for each of 16 recently active pages, the offset of the last miss and up to three of the most recent non-zero offset deltas inside that page.

Three global prediction tables are keyed by delta histories of length one, two and three. Each table maps a history to a predicted next delta and a 2-bit confidence. On every miss the tables are trained with the delta just observed. The longest history that has a matching entry supplies the prediction. Because the tables are shared by all pages, an ordering learned in one page produces prefetches in a fresh page after that page's second miss. The ordering does not have to repeat inside the fresh page.

No program counter is used. A prediction leaves on the prefetch port one cycle after the miss that caused it. It is dropped when its confidence is too low or when the predicted line falls outside the page.

Top module: `delta_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `pf_valid` is low.
- R2: `miss_line[25:6]` is the page and `miss_line[5:0]` is the line offset. A miss to a page that the tracker does not hold allocates a tracker slot with an empty history and issues no prefetch. Deltas are only formed between two misses of the same page.
- R3: A miss whose offset equals the page's last recorded offset issues no prefetch and leaves that page's offset and history unchanged.
- R4: A prefetch appears exactly one cycle after the accepted miss that produced it. At most one prefetch follows each miss, and `pf_valid` is never high unless `miss_valid` was high in the previous cycle.
- R5: A newly written table entry starts at confidence 1. An agreeing delta raises confidence up to a limit of 3. A prefetch is issued only when the selected entry has confidence 2 or more.
- R6: When tables of several history lengths all match, the prediction is taken from the longest one, even if a shorter one predicts a different delta.
- R7: The tables are shared across pages, so a pattern trained in other pages yields a prefetch on the second miss of a new page.
- R8: The predicted offset (miss offset plus selected delta) must lie in 0..63; otherwise nothing is issued. `pf_line` carries the miss's page in bits 25:6 and the predicted offset in bits 5:0.
- R9: A training delta that differs from the stored one lowers confidence by 1. If confidence is already 0, the stored delta is replaced and confidence becomes 1.
- R10: The tracker holds 16 pages. When a new page arrives and all slots are in use, the least recently updated page is evicted.
- R11: Each table holds 16 entries. A new key fills the lowest-numbered empty entry, or else the least recently trained one.
- R12: The prediction for a miss reads the tables as they were before that same miss trains them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A cache-line miss is presented this cycle |
| miss_line | input | 26 | Physical line address of the miss: page in [25:6], offset in [5:0] |
| pf_valid | output | 1 | A prefetch request is presented this cycle |
| pf_line | output | 26 | Physical line address to prefetch |

## Verification
Training and prediction fall in the same cycle on every miss that extends a page history, often on the very entry being trained. A constant stride drives the key that is being strengthened into the lookup at the same time. The bench checks the exact miss at which the first prefetch appears: it must come one miss later than a read-after-training design would give. A reference model computes the prediction before it applies the training, and it is compared against the port on every cycle of a seeded random stream in which pages reuse one global delta ordering.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  // Signed distance between two line offsets of one page.
  function automatic int line_delta(int cur_off, int prev_off);
    return cur_off - prev_off;
  endfunction

  // True when offset plus delta still names a line of the same page.
  function automatic bit stays_in_page(int off, int delta, int lines);
    int tgt;
    tgt = off + delta;
    return (tgt >= 0) && (tgt < lines);
  endfunction

  // Confidence after one training event.
  // agree: step up to cmax. disagree: step down, or restart at 1 from 0.
  function automatic int conf_next(int c, bit agree, int cmax);
    if (agree) return (c < cmax) ? c + 1 : c;
    return (c > 0) ? c - 1 : 1;
  endfunction

endpackage

// File: rtl/dpf_lru.sv
module dpf_lru #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // Ages form a permutation of 0..N-1; N-1 marks the oldest slot.
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == IW'(N - 1)) victim_idx = IW'(i);
  end
endmodule

// File: rtl/dpf_page_tracker.sv
module dpf_page_tracker #(
  parameter int PN_W     = 20,
  parameter int OFF_W    = 6,
  parameter int DW       = 7,
  parameter int HIST_MAX = 3,
  parameter int PAGES    = 16,
  parameter int CNT_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PN_W-1:0]        lk_page,
  output logic                   hit,
  output logic [OFF_W-1:0]       rd_off,
  output logic [HIST_MAX*DW-1:0] rd_hist,
  output logic [CNT_W-1:0]       rd_cnt,
  input  logic                   alloc_en,
  input  logic                   upd_en,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [HIST_MAX*DW-1:0] wr_hist,
  input  logic [CNT_W-1:0]       wr_cnt
);
  localparam int IW = $clog2(PAGES);

  logic                   vld_q  [PAGES];
  logic [PN_W-1:0]        page_q [PAGES];
  logic [OFF_W-1:0]       off_q  [PAGES];
  logic [HIST_MAX*DW-1:0] hist_q [PAGES];
  logic [CNT_W-1:0]       cnt_q  [PAGES];

  logic [IW-1:0] hit_idx, free_idx, lru_idx, wr_idx;
  logic          has_free, touch;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < PAGES; i++)
      if (vld_q[i] && page_q[i] == lk_page) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
  end

  // Lowest-numbered empty slot wins.
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
  end

  assign touch  = alloc_en | upd_en;
  assign wr_idx = alloc_en ? (has_free ? free_idx : lru_idx) : hit_idx;

  dpf_lru #(.N(PAGES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (touch),
    .touch_idx  (wr_idx),
    .victim_idx (lru_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) begin
        vld_q[i]  <= 1'b0;
        page_q[i] <= '0;
        off_q[i]  <= '0;
        hist_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else if (touch) begin
      vld_q[wr_idx]  <= 1'b1;
      page_q[wr_idx] <= lk_page;
      off_q[wr_idx]  <= wr_off;
      hist_q[wr_idx] <= wr_hist;
      cnt_q[wr_idx]  <= wr_cnt;
    end
  end

  assign rd_off  = off_q[hit_idx];
  assign rd_hist = hist_q[hit_idx];
  assign rd_cnt  = cnt_q[hit_idx];
endmodule

// File: rtl/dpf_pred_table.sv
module dpf_pred_table
  import dpf_pkg::*;
#(
  parameter int HLEN    = 1,
  parameter int ENTRIES = 16,
  parameter int DW      = 7,
  parameter int CONF_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HLEN*DW-1:0]   lk_key,
  output logic                 lk_hit,
  output logic signed [DW-1:0] lk_delta,
  output logic [CONF_W-1:0]    lk_conf,
  input  logic                 tr_en,
  input  logic [HLEN*DW-1:0]   tr_key,
  input  logic signed [DW-1:0] tr_delta
);
  localparam int KW       = HLEN * DW;
  localparam int IW       = $clog2(ENTRIES);
  localparam int CONF_MAX = (1 << CONF_W) - 1;

  logic                 vld_q [ENTRIES];
  logic [KW-1:0]        key_q [ENTRIES];
  logic signed [DW-1:0] dl_q  [ENTRIES];
  logic [CONF_W-1:0]    cf_q  [ENTRIES];

  logic [IW-1:0] lk_idx, tr_idx, free_idx, lru_idx, wr_idx;
  logic          tr_hit, has_free, agree, replace;
  logic [CONF_W-1:0] cf_upd;

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    tr_hit = 1'b0;
    tr_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && key_q[i] == lk_key) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
      if (vld_q[i] && key_q[i] == tr_key) begin
        tr_hit = 1'b1;
        tr_idx = IW'(i);
      end
    end
  end

  assign lk_delta = dl_q[lk_idx];
  assign lk_conf  = cf_q[lk_idx];

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
  end

  assign wr_idx  = tr_hit ? tr_idx : (has_free ? free_idx : lru_idx);
  assign agree   = (dl_q[tr_idx] == tr_delta);
  assign replace = !agree && (cf_q[tr_idx] == '0);
  assign cf_upd  = CONF_W'(conf_next(int'(cf_q[tr_idx]), agree, CONF_MAX));

  dpf_lru #(.N(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (tr_en),
    .touch_idx  (wr_idx),
    .victim_idx (lru_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        key_q[i] <= '0;
        dl_q[i]  <= '0;
        cf_q[i]  <= '0;
      end
    end else if (tr_en) begin
      if (tr_hit) begin
        cf_q[wr_idx] <= cf_upd;
        if (replace) dl_q[wr_idx] <= tr_delta;
      end else begin
        vld_q[wr_idx] <= 1'b1;
        key_q[wr_idx] <= tr_key;
        dl_q[wr_idx]  <= tr_delta;
        cf_q[wr_idx]  <= CONF_W'(1);
      end
    end
  end
endmodule

// File: rtl/delta_prefetcher.sv
module delta_prefetcher
  import dpf_pkg::*;
#(
  parameter int LA_W       = 26,
  parameter int OFF_W      = 6,
  parameter int TRK_PAGES  = 16,
  parameter int HIST_MAX   = 3,
  parameter int PT_ENTRIES = 16,
  parameter int CONF_W     = 2,
  parameter int MIN_CONF   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_valid,
  input  logic [LA_W-1:0] miss_line,
  output logic            pf_valid,
  output logic [LA_W-1:0] pf_line
);
  localparam int PN_W  = LA_W - OFF_W;
  localparam int DW    = OFF_W + 1;
  localparam int LINES = 1 << OFF_W;
  localparam int CNT_W = $clog2(HIST_MAX + 1);

  logic [PN_W-1:0]  miss_page;
  logic [OFF_W-1:0] miss_off;
  assign miss_page = miss_line[LA_W-1:OFF_W];
  assign miss_off  = miss_line[OFF_W-1:0];

  // Page history
  logic                   trk_hit;
  logic [OFF_W-1:0]       trk_off;
  logic [HIST_MAX*DW-1:0] trk_hist, new_hist, wr_hist;
  logic [CNT_W-1:0]       trk_cnt, new_cnt, wr_cnt;
  logic signed [DW-1:0]   delta;
  logic                   zero_delta, accept_hit, alloc_page;

  assign delta      = DW'(line_delta(int'(miss_off), int'(trk_off)));
  assign zero_delta = (delta == '0);
  assign accept_hit = miss_valid && trk_hit && !zero_delta;
  assign alloc_page = miss_valid && !trk_hit;
  assign new_cnt    = (trk_cnt == CNT_W'(HIST_MAX)) ? trk_cnt : trk_cnt + 1'b1;

  generate
    if (HIST_MAX > 1) begin : g_shift
      assign new_hist = {trk_hist[HIST_MAX*DW-DW-1:0], delta};
    end else begin : g_single
      assign new_hist = delta;
    end
  endgenerate

  assign wr_hist = alloc_page ? '0 : new_hist;
  assign wr_cnt  = alloc_page ? '0 : new_cnt;

  dpf_page_tracker #(
    .PN_W(PN_W), .OFF_W(OFF_W), .DW(DW), .HIST_MAX(HIST_MAX),
    .PAGES(TRK_PAGES), .CNT_W(CNT_W)
  ) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_page  (miss_page),
    .hit      (trk_hit),
    .rd_off   (trk_off),
    .rd_hist  (trk_hist),
    .rd_cnt   (trk_cnt),
    .alloc_en (alloc_page),
    .upd_en   (accept_hit),
    .wr_off   (miss_off),
    .wr_hist  (wr_hist),
    .wr_cnt   (wr_cnt)
  );

  // Prediction tables, one per history length
  logic [HIST_MAX-1:0]  lk_hit, tr_en, tbl_match;
  logic signed [DW-1:0] lk_delta [HIST_MAX];
  logic [CONF_W-1:0]    lk_conf  [HIST_MAX];

  generate
    for (genvar k = 1; k <= HIST_MAX; k++) begin : g_tbl
      dpf_pred_table #(
        .HLEN(k), .ENTRIES(PT_ENTRIES), .DW(DW), .CONF_W(CONF_W)
      ) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_key   (new_hist[k*DW-1:0]),
        .lk_hit   (lk_hit[k-1]),
        .lk_delta (lk_delta[k-1]),
        .lk_conf  (lk_conf[k-1]),
        .tr_en    (tr_en[k-1]),
        .tr_key   (trk_hist[k*DW-1:0]),
        .tr_delta (delta)
      );
      assign tr_en[k-1]     = accept_hit && (trk_cnt >= CNT_W'(k));
      assign tbl_match[k-1] = lk_hit[k-1] && (new_cnt >= CNT_W'(k));
    end
  endgenerate

  // Longest matching history wins
  logic                 sel_any;
  logic signed [DW-1:0] sel_delta;
  logic [CONF_W-1:0]    sel_conf;
  logic [CNT_W-1:0]     sel_len;

  always_comb begin
    sel_any   = 1'b0;
    sel_delta = '0;
    sel_conf  = '0;
    sel_len   = '0;
    for (int k = 0; k < HIST_MAX; k++)
      if (tbl_match[k]) begin
        sel_any   = 1'b1;
        sel_delta = lk_delta[k];
        sel_conf  = lk_conf[k];
        sel_len   = CNT_W'(k + 1);
      end
  end

  logic             in_page, pf_fire;
  logic [OFF_W-1:0] tgt_off;

  assign in_page = stays_in_page(int'(miss_off), int'(sel_delta), LINES);
  assign tgt_off = OFF_W'(int'(miss_off) + int'(sel_delta));
  assign pf_fire = accept_hit && sel_any && in_page && (sel_conf >= CONF_W'(MIN_CONF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
    end else begin
      pf_valid <= pf_fire;
      if (pf_fire) pf_line <= {miss_page, tgt_off};
    end
  end
endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
  parameter int LA_W     = 26,
  parameter int OFF_W    = 6,
  parameter int HIST_MAX = 3,
  parameter int CONF_W   = 2,
  parameter int MIN_CONF = 2,
  parameter int CNT_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                miss_valid,
  input logic [LA_W-1:0]     miss_line,
  input logic                pf_valid,
  input logic [LA_W-1:0]     pf_line,
  input logic                trk_hit,
  input logic                zero_delta,
  input logic                pf_fire,
  input logic [CONF_W-1:0]   sel_conf,
  input logic [CNT_W-1:0]    sel_len,
  input logic [HIST_MAX-1:0] tbl_match
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !pf_valid);

  // R2
  new_page_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !trk_hit) |=> !pf_valid);

  // R3
  zero_delta_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && trk_hit && zero_delta) |=> !pf_valid);

  // R4
  pf_follows_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(miss_valid));

  // R5
  conf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fire |-> (sel_conf >= CONF_W'(MIN_CONF)));

  // R6
  longest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_match[HIST_MAX-1] |-> (sel_len == CNT_W'(HIST_MAX)));

  // R8
  same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_line[LA_W-1:OFF_W] == $past(miss_line[LA_W-1:OFF_W])));
endmodule

bind delta_prefetcher dpf_checker #(
  .LA_W(LA_W), .OFF_W(OFF_W), .HIST_MAX(HIST_MAX),
  .CONF_W(CONF_W), .MIN_CONF(MIN_CONF), .CNT_W(CNT_W)
) i_dpf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_line  (miss_line),
  .pf_valid   (pf_valid),
  .pf_line    (pf_line),
  .trk_hit    (trk_hit),
  .zero_delta (zero_delta),
  .pf_fire    (pf_fire),
  .sel_conf   (sel_conf),
  .sel_len    (sel_len),
  .tbl_match  (tbl_match)
);

// File: tb/test_delta_prefetcher.sv
module test_delta_prefetcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [25:0] miss_line = '0;
  logic        pf_valid;
  logic [25:0] pf_line;

  always #5 clk = ~clk;

  delta_prefetcher i_delta_prefetcher (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .pf_valid(pf_valid), .pf_line(pf_line)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state
  int tv[16], tpg[16], tlast[16], tc[16], tt[16];
  int th[16][3];
  int pv[3][16], pd[3][16], pc[3][16], pt[3][16];
  int pk[3][16][3];
  int now_t = 0;

  // Pending expectations for the cycle after a miss
  bit    have_pend = 0;
  bit    pend_v;
  logic [25:0] pend_a;
  string pend_tag;
  bit    hand_on = 0;
  bit    hand_v;
  int    hand_off;
  string hand_tag;

  function automatic logic [25:0] mk(int page, int off);
    return {20'(page), 6'(off)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(int page, int off, output bit v, output logic [25:0] a);
    int idx, d, c, nc, e, k;
    int h[3];
    int nh[3];
    bit found, keq;
    int sd, sc, best;
    v = 0; a = '0; now_t++;
    idx = -1;
    for (int i = 0; i < 16; i++) if (tv[i] != 0 && tpg[i] == page) idx = i;
    if (idx < 0) begin
      best = -1;
      for (int i = 15; i >= 0; i--) if (tv[i] == 0) best = i;
      if (best < 0) begin
        best = 0;
        for (int i = 1; i < 16; i++) if (tt[i] < tt[best]) best = i;
      end
      tv[best] = 1; tpg[best] = page; tlast[best] = off; tc[best] = 0;
      for (int j = 0; j < 3; j++) th[best][j] = 0;
      tt[best] = now_t;
      return;
    end
    d = off - tlast[idx];
    if (d == 0) return;
    for (int j = 0; j < 3; j++) h[j] = th[idx][j];
    c = tc[idx];
    nh[0] = d; nh[1] = h[0]; nh[2] = h[1];
    nc = (c < 3) ? c + 1 : 3;
    // predict from untrained state
    found = 0; sd = 0; sc = 0;
    for (k = 3; k >= 1; k--) begin
      if (!found && nc >= k) begin
        for (e = 0; e < 16; e++) begin
          keq = (pv[k-1][e] != 0);
          for (int j = 0; j < k; j++) if (pk[k-1][e][j] != nh[j]) keq = 0;
          if (keq) begin found = 1; sd = pd[k-1][e]; sc = pc[k-1][e]; end
        end
      end
    end
    if (found && sc >= 2 && off + sd >= 0 && off + sd <= 63) begin
      v = 1; a = mk(page, off + sd);
    end
    // train
    for (k = 1; k <= 3; k++) begin
      if (c >= k) begin
        best = -1;
        for (e = 0; e < 16; e++) begin
          keq = (pv[k-1][e] != 0);
          for (int j = 0; j < k; j++) if (pk[k-1][e][j] != h[j]) keq = 0;
          if (keq) best = e;
        end
        if (best >= 0) begin
          if (pd[k-1][best] == d) begin
            if (pc[k-1][best] < 3) pc[k-1][best]++;
          end else if (pc[k-1][best] > 0) pc[k-1][best]--;
          else begin pd[k-1][best] = d; pc[k-1][best] = 1; end
        end else begin
          for (e = 15; e >= 0; e--) if (pv[k-1][e] == 0) best = e;
          if (best < 0) begin
            best = 0;
            for (e = 1; e < 16; e++) if (pt[k-1][e] < pt[k-1][best]) best = e;
          end
          pv[k-1][best] = 1; pd[k-1][best] = d; pc[k-1][best] = 1;
          for (int j = 0; j < 3; j++) pk[k-1][best][j] = (j < k) ? h[j] : 0;
        end
        pt[k-1][best] = now_t;
      end
    end
    tlast[idx] = off;
    for (int j = 0; j < 3; j++) th[idx][j] = nh[j];
    tc[idx] = nc; tt[idx] = now_t;
  endtask

  task automatic check_pending();
    if (have_pend) begin
      chk((pf_valid === pend_v) && (!pend_v || pf_line === pend_a), pend_tag,
          "prefetch vs model", {5'd0, pf_valid, pf_line}, {5'd0, pend_v, pend_a});
    end
    if (hand_on) begin
      chk((pf_valid === hand_v) && (!hand_v || int'(pf_line[5:0]) == hand_off), hand_tag,
          "prefetch vs hand value", {5'd0, pf_valid, pf_line}, hand_v ? hand_off : 0);
      hand_on = 0;
    end
  endtask

  task automatic step(bit v, int page, int off, string tag);
    @(negedge clk);
    check_pending();
    miss_valid = v;
    miss_line  = mk(page, off);
    if (v) model(page, off, pend_v, pend_a);
    else pend_v = 0;
    pend_tag = tag; have_pend = 1;
  endtask

  task automatic expect_pf(bit v, int off, string tag);
    hand_on = 1; hand_v = v; hand_off = off; hand_tag = tag;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int pat[6] = '{1, 2, 1, 3, 2, -1};
  int goff[20], gstep[20];

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pf_valid === 1'b0, "R1", "pf_valid in reset", pf_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pf_valid === 1'b0, "R1", "pf_valid after reset", pf_valid, 0);

    // Stride 2 in page 1: first prefetch only at offset 12
    step(1, 1, 0, "R2");  expect_pf(0, 0, "R2 first miss of page");
    step(1, 1, 2, "R2");
    step(1, 1, 4, "R5");
    step(1, 1, 6, "R5");  expect_pf(0, 0, "R5 confidence 1 blocks");
    step(1, 1, 8, "R12"); expect_pf(0, 0, "R12 lookup precedes training");
    step(1, 1, 10, "R12"); expect_pf(0, 0, "R6 R12 longest entry still weak");
    step(1, 1, 12, "R4"); expect_pf(1, 14, "R4 first prefetch");
    // Global reuse in page 2
    step(1, 2, 10, "R2"); expect_pf(0, 0, "R2 new page");
    step(1, 2, 12, "R7"); expect_pf(1, 14, "R7 learned elsewhere");
    step(1, 2, 12, "R3"); expect_pf(0, 0, "R3 repeat line");
    step(1, 2, 14, "R3"); expect_pf(1, 16, "R3 history intact");
    // Page edge
    step(1, 3, 59, "R8");
    step(1, 3, 61, "R8"); expect_pf(1, 63, "R8 last line allowed");
    step(1, 3, 63, "R8"); expect_pf(0, 0, "R8 beyond page");
    // Longest match: pattern B then A
    for (int p = 10; p < 12; p++) begin
      step(1, p, 0, "R6"); step(1, p, 2, "R6"); step(1, p, 3, "R6"); step(1, p, 10, "R6");
    end
    for (int p = 12; p < 14; p++) begin
      step(1, p, 0, "R6"); step(1, p, 3, "R6"); step(1, p, 4, "R6"); step(1, p, 9, "R6");
    end
    step(1, 14, 0, "R6"); step(1, 14, 3, "R6");
    step(1, 14, 4, "R6"); expect_pf(1, 9, "R6 two-delta entry wins");
    // Replacement at zero confidence
    step(1, 15, 0, "R9"); step(1, 15, 1, "R9"); step(1, 15, 2, "R9");
    step(1, 16, 0, "R9"); step(1, 16, 1, "R9");
    step(1, 16, 2, "R9"); expect_pf(0, 0, "R9 replaced entry at confidence 1");
    step(1, 16, 3, "R9"); expect_pf(1, 4, "R9 replaced delta predicts");
    // Tracker eviction
    for (int p = 200; p < 216; p++) step(1, p, 0, "R10");
    step(1, 16, 4, "R10"); expect_pf(0, 0, "R10 evicted page restarts");
    step(0, 0, 0, "R4");

    // Seeded random traffic over a pool larger than the tracker
    for (int i = 0; i < 20; i++) begin goff[i] = $urandom % 64; gstep[i] = 0; end
    for (int n = 0; n < 3000; n++) begin
      int pi, r, o;
      pi = $urandom % 20;
      r  = $urandom % 10;
      if (r == 0) o = goff[pi];
      else if (r == 1) o = $urandom % 64;
      else begin
        o = goff[pi] + pat[gstep[pi] % 6];
        gstep[pi]++;
      end
      o = o & 63;
      goff[pi] = o;
      if ($urandom % 5 == 0) step(0, 0, 0, "R4");
      step(1, 100 + pi, o, "R9 R10 R11 R12 random");
    end
    step(0, 0, 0, "R4");
    @(negedge clk);
    check_pending();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule